// File: doc/BRIEF.md
# Switching Regulator Fault and Soft-Start Supervisor

This block is the digital supervisor of a synchronous buck regulator. The analog comparators sit outside it. They hand it one synchronous bit each for overcurrent, overvoltage, output-inside-window and input undervoltage, and a one-clock strobe marks the end of every switching period. The block decides when the power stage may switch, produces the ramp code that raises the reference during start-up, flags when start-up has finished, and drives the power-good output.

A sequencer with four states (off, ramping, running, hiccup) owns the rest of the logic. It uses four counters:

- an overcurrent integrator that counts up and down and clamps at both ends;
- a counter of consecutive overvoltage periods;
- a ramp counter for the start-up phase;
- a restart timer for the hiccup phase.

A sustained overcurrent or overvoltage stops the power stage. The stage stays off for a fixed number of periods and then goes through a complete new start-up ramp. Removing the enable, or raising undervoltage, forces the block to off with every counter cleared.

Top module: `bsup_seq`

## Requirements
- R1: After reset, and whenever the block is off, pwm_en_o is 0, ss_code_o is 0, ss_done_o is 0 and pgood_o is 0.
- R2: When the block is off with en_i=1 and uvlo_i=0, the first strobe starts the ramp. pwm_en_o becomes 1 and ss_code_o is 0.
- R3: During the ramp, ss_code_o equals the upper CODE_W bits of an SS_W-bit count of the strobes taken in the ramp so far. The 2^SS_W-th strobe ends the ramp. At that point ss_done_o becomes 1 and ss_code_o is all ones for as long as the block is running.
- R4: Clock edges with cyc_stb_i=0 advance no counter. They do not break an overvoltage run, and they do not move the ramp.
- R5: While switching is enabled, each strobe with oc_i=1 adds one to an OC_W-bit integrator, and each strobe with oc_i=0 subtracts one. The integrator never goes below zero. When it reaches 2^OC_W-1, switching stops: the block enters hiccup.
- R6: OV_RUN consecutive strobes with ov_i=1 stop switching and enter hiccup. A strobe with ov_i=0 restarts the run from zero.
- R7: In hiccup, pwm_en_o and ss_code_o are 0. After HIC_CYC strobes in hiccup, a new ramp starts from code 0 with the fault counters cleared.
- R8: With en_i=0 or uvlo_i=1, the block is off after the next clock edge, strobe or not, and every counter is cleared. A later enable starts again from R2.
- R9: pgood_o is 1 exactly when pwm_en_o is 1 and pgwin_i is 1, in the same cycle.
- R10: If a fault trips on the same strobe that would end the ramp, the fault wins. The block enters hiccup and ss_done_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Converter enable |
| uvlo_i | input | 1 | Input undervoltage, active high |
| cyc_stb_i | input | 1 | One-clock strobe at the end of each switching period |
| oc_i | input | 1 | Overcurrent comparator result for this period |
| ov_i | input | 1 | Overvoltage comparator result for this period |
| pgwin_i | input | 1 | Output inside regulation window |
| pwm_en_o | output | 1 | Power stage allowed to switch |
| ss_code_o | output | CODE_W | Reference ramp code |
| ss_done_o | output | 1 | Start-up finished, full reference applied |
| pgood_o | output | 1 | Power good |

## Verification
Every state-driven output (pwm_en_o, ss_code_o, ss_done_o) moves at the first rising edge that sees the strobe or the enable change, so it is due one clock later. pgood_o follows pgwin_i within the same cycle. The bench changes inputs on the falling edge and reads results on the next falling edge, half a clock after the edge that should update them. Each expected value is a count of strobes derived from R3 to R7. The bench checks the boundary strobes on both sides: the one just before a trip or a ramp end, and the one that causes it.

// File: rtl/bsup_pkg.sv
package bsup_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_SOFT = 2'd1,
        ST_RUN  = 2'd2,
        ST_HIC  = 2'd3
    } bsup_state_e;
endpackage

// File: rtl/bsup_oc_integ.sv
module bsup_oc_integ #(
    parameter int W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic step_i,
    input  logic up_i,
    output logic fire_o
);
    localparam logic [W-1:0] TOP = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
    } integ_t;

    integ_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (step_i) begin
            if (up_i && st_q.cnt != TOP)
                st_d.cnt = st_q.cnt + 1'b1;
            else if (!up_i && st_q.cnt != '0)
                st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    assign fire_o = !clr_i && step_i && (st_d.cnt == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: a down-step at zero leaves the integrator at zero
    assert_oc_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && step_i && !up_i && st_q.cnt == '0) |=> st_q.cnt == '0);

    // R5: an up-step below the top adds exactly one
    assert_oc_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && step_i && up_i && st_q.cnt != TOP) |=> st_q.cnt == $past(st_q.cnt) + 1'b1);
endmodule

// File: rtl/bsup_ov_run.sv
module bsup_ov_run #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic step_i,
    input  logic hit_i,
    output logic trip_o
);
    localparam int RUN_W = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [RUN_W-1:0] run;
    } run_t;

    run_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.run = '0;
        end else if (step_i) begin
            if (!hit_i)
                st_d.run = '0;
            else if (st_q.run != RUN_W'(LIMIT))
                st_d.run = st_q.run + 1'b1;
        end
    end

    assign trip_o = !clr_i && step_i && hit_i && (st_q.run == RUN_W'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: a clean period breaks the run
    assert_ov_break_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && step_i && !hit_i) |=> st_q.run == '0);

    // R4: no strobe, no change
    assert_ov_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !step_i) |=> $stable(st_q.run));
endmodule

// File: rtl/bsup_ramp.sv
module bsup_ramp #(
    parameter int W      = 12,
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              step_i,
    output logic [CODE_W-1:0] code_o,
    output logic              last_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } ramp_t;

    ramp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i)       st_d.cnt = '0;
        else if (step_i) st_d.cnt = st_q.cnt + 1'b1;
    end

    assign code_o = st_q.cnt[W-1 -: CODE_W];
    assign last_o = !clr_i && step_i && (&st_q.cnt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: the ramp only moves on a strobe
    assert_ramp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !step_i) |=> $stable(code_o));
endmodule

// File: rtl/bsup_seq.sv
module bsup_seq
    import bsup_pkg::*;
#(
    parameter int OC_W    = 4,
    parameter int OV_RUN  = 32,
    parameter int HIC_CYC = 16,
    parameter int SS_W    = 12,
    parameter int CODE_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              uvlo_i,
    input  logic              cyc_stb_i,
    input  logic              oc_i,
    input  logic              ov_i,
    input  logic              pgwin_i,
    output logic              pwm_en_o,
    output logic [CODE_W-1:0] ss_code_o,
    output logic              ss_done_o,
    output logic              pgood_o
);
    localparam int HIC_W = (HIC_CYC > 1) ? $clog2(HIC_CYC) : 1;
    localparam logic [HIC_W-1:0] HIC_LAST = HIC_W'(HIC_CYC - 1);

    typedef struct packed {
        bsup_state_e      st;
        logic [HIC_W-1:0] hic;
    } seq_t;

    seq_t st_d, st_q;

    logic              allow;
    logic              active;
    logic              oc_fire;
    logic              ov_trip;
    logic              ramp_last;
    logic [CODE_W-1:0] ramp_code;

    assign allow  = en_i && !uvlo_i;
    assign active = (st_q.st == ST_SOFT) || (st_q.st == ST_RUN);

    bsup_oc_integ #(.W(OC_W)) i_oc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (!active || !allow),
        .step_i (cyc_stb_i),
        .up_i   (oc_i),
        .fire_o (oc_fire)
    );

    bsup_ov_run #(.LIMIT(OV_RUN)) i_ov (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (!active || !allow),
        .step_i (cyc_stb_i),
        .hit_i  (ov_i),
        .trip_o (ov_trip)
    );

    bsup_ramp #(.W(SS_W), .CODE_W(CODE_W)) i_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  ((st_q.st != ST_SOFT) || !allow),
        .step_i (cyc_stb_i),
        .code_o (ramp_code),
        .last_o (ramp_last)
    );

    always_comb begin
        st_d = st_q;
        if (!allow) begin
            st_d.st  = ST_OFF;
            st_d.hic = '0;
        end else if (cyc_stb_i) begin
            unique case (st_q.st)
                ST_OFF: begin
                    st_d.st = ST_SOFT;
                end
                ST_SOFT: begin
                    if (oc_fire || ov_trip) begin
                        st_d.st  = ST_HIC;
                        st_d.hic = '0;
                    end else if (ramp_last) begin
                        st_d.st = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (oc_fire || ov_trip) begin
                        st_d.st  = ST_HIC;
                        st_d.hic = '0;
                    end
                end
                ST_HIC: begin
                    if (st_q.hic == HIC_LAST) st_d.st  = ST_SOFT;
                    else                      st_d.hic = st_q.hic + 1'b1;
                end
                default: st_d.st = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{st: ST_OFF, hic: '0};
        else        st_q <= st_d;
    end

    assign pwm_en_o  = active;
    assign ss_done_o = (st_q.st == ST_RUN);
    assign ss_code_o = (st_q.st == ST_RUN)  ? '1 :
                       (st_q.st == ST_SOFT) ? ramp_code : '0;
    assign pgood_o   = active && pgwin_i;

    // R8: a lost enable or undervoltage silences the stage one edge later
    assert_drop_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i || uvlo_i) |=> (!pwm_en_o && !ss_done_o && ss_code_o == '0));

    // R3: finished start-up always carries the full reference
    assert_done_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ss_done_o |-> (&ss_code_o));

    // R9: power good never shows without switching
    assert_pg_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pgood_o |-> pwm_en_o);

    // R7: hiccup stays put between strobes
    assert_hic_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == ST_HIC && allow && !cyc_stb_i) |=> (st_q.st == ST_HIC && !pwm_en_o));
endmodule

// File: tb/test_bsup_seq.sv
module test_bsup_seq;
    localparam int OC_W    = 4;
    localparam int OV_RUN  = 5;
    localparam int HIC_CYC = 4;
    localparam int SS_W    = 6;
    localparam int CODE_W  = 3;
    localparam int SS_LEN  = 1 << SS_W;
    localparam int SHIFT   = SS_W - CODE_W;
    localparam int OC_TOP  = (1 << OC_W) - 1;
    localparam int FULL    = (1 << CODE_W) - 1;

    logic clk = 1'b0;
    logic rst_n, en_i, uvlo_i, cyc_stb_i, oc_i, ov_i, pgwin_i;
    logic pwm_en_o, ss_done_o, pgood_o;
    logic [CODE_W-1:0] ss_code_o;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    bsup_seq #(.OC_W(OC_W), .OV_RUN(OV_RUN), .HIC_CYC(HIC_CYC),
               .SS_W(SS_W), .CODE_W(CODE_W)) i_bsup_seq (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .uvlo_i(uvlo_i),
        .cyc_stb_i(cyc_stb_i), .oc_i(oc_i), .ov_i(ov_i), .pgwin_i(pgwin_i),
        .pwm_en_o(pwm_en_o), .ss_code_o(ss_code_o), .ss_done_o(ss_done_o),
        .pgood_o(pgood_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input bit stb, input bit oc, input bit ov);
        cyc_stb_i = stb;
        oc_i      = oc;
        ov_i      = ov;
        @(posedge clk);
        @(negedge clk);
        cyc_stb_i = 1'b0;
    endtask

    task automatic steps(input int n, input bit oc, input bit ov);
        for (int i = 0; i < n; i++) step(1'b1, oc, ov);
    endtask

    task automatic sum_up();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        sum_up();
    end

    initial begin
        rst_n = 0; en_i = 0; uvlo_i = 0; cyc_stb_i = 0;
        oc_i = 0; ov_i = 0; pgwin_i = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pwm", pwm_en_o, 0);
        chk("R1 code", ss_code_o, 0);
        chk("R1 done", ss_done_o, 0);
        chk("R1 pg", pgood_o, 0);
        steps(3, 0, 0);
        chk("R1 off while disabled", pwm_en_o, 0);

        // R8 undervoltage blocks start
        en_i = 1; uvlo_i = 1;
        step(1, 0, 0);
        chk("R8 uvlo holds off", pwm_en_o, 0);
        uvlo_i = 0;

        // R2 start
        step(1, 0, 0);
        chk("R2 pwm", pwm_en_o, 1);
        chk("R2 code", ss_code_o, 0);
        chk("R2 done", ss_done_o, 0);

        // R3 ramp sweep
        for (int k = 1; k < SS_LEN; k++) begin
            step(1, 0, 0);
            chk("R3 code", ss_code_o, k >> SHIFT);
            chk("R3 done low", ss_done_o, 0);
            if (k == 20) begin
                pgwin_i = 0;
                step(0, 0, 0);
                chk("R9 pg window low", pgood_o, 0);
                chk("R4 code held", ss_code_o, k >> SHIFT);
                pgwin_i = 1;
                #1;
                chk("R9 pg window high", pgood_o, 1);
            end
        end
        step(1, 0, 0);
        chk("R3 done", ss_done_o, 1);
        chk("R3 full code", ss_code_o, FULL);

        // R5 balanced up/down patterns
        for (int n = 1; n < OC_TOP; n++) begin
            steps(n, 1, 0);
            steps(n, 0, 0);
            chk("R5 balanced", pwm_en_o, 1);
        end
        steps(3, 0, 0);
        chk("R5 floor", pwm_en_o, 1);
        steps(OC_TOP - 1, 1, 0);
        chk("R5 below top", pwm_en_o, 1);
        for (int i = 0; i < 3; i++) step(0, 1, 0);
        chk("R4 oc without strobe", pwm_en_o, 1);
        step(1, 1, 0);
        chk("R5 trip pwm", pwm_en_o, 0);
        chk("R5 trip done", ss_done_o, 0);
        chk("R7 code in hiccup", ss_code_o, 0);

        // R7 hiccup timing
        for (int i = 1; i < HIC_CYC; i++) begin
            step(1, 0, 0);
            chk("R7 hiccup holds", pwm_en_o, 0);
        end
        step(0, 0, 0);
        chk("R7 hiccup no strobe", pwm_en_o, 0);
        step(1, 0, 0);
        chk("R7 restart pwm", pwm_en_o, 1);
        chk("R7 restart code", ss_code_o, 0);
        steps(OC_TOP - 1, 1, 0);
        chk("R7 integrator cleared", pwm_en_o, 1);
        steps(OC_TOP - 1, 0, 0);
        steps(SS_LEN - 2 * (OC_TOP - 1), 0, 0);
        chk("R3 done after restart", ss_done_o, 1);

        // R5 mixed pattern: +10 -4 then 9 more to reach top
        steps(10, 1, 0);
        steps(4, 0, 0);
        steps(8, 1, 0);
        chk("R5 mixed below", pwm_en_o, 1);
        step(1, 1, 0);
        chk("R5 mixed trip", pwm_en_o, 0);
        steps(HIC_CYC, 0, 0);
        chk("R7 second restart", pwm_en_o, 1);

        // R10 fault on final ramp strobe
        steps(SS_LEN - OC_TOP, 0, 0);
        steps(OC_TOP - 1, 1, 0);
        chk("R10 pre pwm", pwm_en_o, 1);
        chk("R10 pre code", ss_code_o, FULL);
        chk("R10 pre done", ss_done_o, 0);
        step(1, 1, 0);
        chk("R10 fault wins pwm", pwm_en_o, 0);
        chk("R10 fault wins done", ss_done_o, 0);
        steps(HIC_CYC, 0, 0);
        steps(SS_LEN, 0, 0);
        chk("R3 run again", ss_done_o, 1);

        // R6 overvoltage run
        steps(OV_RUN - 1, 0, 1);
        step(1, 0, 0);
        chk("R6 broken run", pwm_en_o, 1);
        steps(2, 0, 1);
        step(0, 0, 0);
        steps(OV_RUN - 3, 0, 1);
        chk("R6 one short", pwm_en_o, 1);
        step(1, 0, 1);
        chk("R6 trip", pwm_en_o, 0);

        // R8 disable in hiccup
        en_i = 0;
        step(0, 0, 0);
        chk("R8 off from hiccup", pwm_en_o, 0);
        en_i = 1;
        step(1, 0, 0);
        chk("R8 fresh start pwm", pwm_en_o, 1);
        chk("R8 fresh start code", ss_code_o, 0);

        // R8 disable mid ramp
        steps(20, 0, 0);
        chk("R3 mid ramp", ss_code_o, 20 >> SHIFT);
        en_i = 0;
        step(0, 0, 0);
        chk("R8 mid ramp pwm", pwm_en_o, 0);
        chk("R8 mid ramp code", ss_code_o, 0);
        chk("R1 pg off", pgood_o, 0);
        en_i = 1;
        step(1, 0, 0);
        chk("R8 ramp restart code", ss_code_o, 0);
        steps(1 << SHIFT, 0, 0);
        chk("R8 ramp from zero", ss_code_o, 1);

        // R8 undervoltage in run
        steps(SS_LEN - (1 << SHIFT), 0, 0);
        chk("R3 run before uvlo", ss_done_o, 1);
        uvlo_i = 1;
        step(0, 0, 0);
        chk("R8 uvlo pwm", pwm_en_o, 0);
        chk("R8 uvlo done", ss_done_o, 0);
        uvlo_i = 0;
        step(1, 0, 0);
        chk("R2 restart after uvlo", ss_code_o, 0);
        chk("R2 pwm after uvlo", pwm_en_o, 1);

        sum_up();
    end
endmodule